// File: doc/BRIEF.md
# Outbound Address Decode Window Unit

This block steers every address a master issues toward one of several target ports. It holds a small bank of programmable windows. Each window names a 64 KB-aligned base, a power-of-two span, a four-bit target code and an eight-bit attribute byte. The lowest few windows can also move the address into a different region of the target's bus and supply a 32-bit high address word.

A narrow register port programs the windows. Writes land on the clock edge, and reads return the stored word in the same cycle. On the lookup side the master presents a 32-bit address with a request strobe. One clock later the block reports the following results:
- hit or miss;
- the winning window number, with the lowest-numbered window taking precedence;
- its target code and attribute;
- the translated 32-bit address;
- the high address word.

When no window matches, the address passes through unchanged.

The usual target codes are 0 for DRAM, 1 for the device bus, 3 for PCI and 4 for PCI Express. Attribute 0x51 selects IO space and 0x59 selects memory space. The device-bus chip selects 0, 1 and 2 use 0x1E, 0x1D and 0x1B, and the boot device uses 0x0F. These codes are only stored and returned; the block does not interpret them.

Top module: `owin_unit`

## Requirements
- R1: After reset every register reads zero, every window is disabled, and each lookup misses.
- R2: Window w occupies byte offsets 16·w to 16·w+15 of the register port. Word 0x0 is control, 0x4 is base, 0x8 is remap low and 0xC is remap high. Address bits 1:0 are ignored, and cfg_rdata reflects cfg_addr combinationally.
- R3: The control word holds (span−1) in 64 KB units in bits 31:16, the attribute in bits 15:8, the target code in bits 7:4 and the enable in bit 0. Bits 3:1 read back zero.
- R4: The base word keeps bits 31:16 only, and bits 15:0 read back zero.
- R5: Only windows 0 to NUM_REMAP−1 (default 4) hold remap registers. Remap low keeps bits 31:16 and remap high keeps all 32 bits. For other windows both remap words read zero and writes to them change nothing.
- R6: A window matches when its enable is 1 and addr[31:16] equals base[31:16] in every bit where the span field is 0.
- R7: If several windows match, the lowest-numbered one supplies all results.
- R8: A hit in a remap-capable window returns {remap_low[31:16], addr[15:0]} and the remap high word. A hit in any other window returns the address unchanged with a high word of zero.
- R9: On a miss, res_miss is 1 and res_hit is 0. Window, target and attribute are zero, the address is unchanged and the high word is zero.
- R10: Results appear in the cycle after each request strobe, with res_valid high for exactly one cycle per request; back-to-back requests are accepted. Without a request, res_valid, res_hit and res_miss are 0 and the other result outputs hold their last values.
- R11: A register write is seen by lookups requested in later cycles. A lookup requested in the same cycle as the write uses the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW (7) | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Address to decode |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Some window matched |
| res_miss | output | 1 | No window matched |
| res_win | output | IDX_W (3) | Winning window number |
| res_target | output | 4 | Target code of the winner |
| res_attr | output | 8 | Attribute of the winner |
| res_addr | output | 32 | Translated address |
| res_addr_hi | output | 32 | High address word |

## Verification
The hardest case to reach is a write and a lookup that touch the same window in the same cycle. The bench drives both in one cycle, first expects the pre-write decision, and then repeats the lookup to see the new one.

Overlapping windows are the other difficult case. Priority only shows when two enabled windows claim the same address. The bench therefore places overlapping windows in both remap-capable and plain slots, then disables the winner and looks again.

An address sweep of about nine thousand points across the whole upper half-word is scored against an arithmetic model of the programmed map. This catches off-by-one errors at the window edges.

// File: rtl/owin_pkg.sv
package owin_pkg;
  localparam int PAGE_BITS = 16;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_BASE = 2'd1,
    REG_RLO  = 2'd2,
    REG_RHI  = 2'd3
  } owin_reg_e;

  typedef struct packed {
    logic [PAGE_BITS-1:0] span;
    logic [7:0]           attr;
    logic [3:0]           tgt;
    logic                 en;
    logic [PAGE_BITS-1:0] base;
    logic [PAGE_BITS-1:0] rlo;
    logic [31:0]          rhi;
  } owin_t;

  localparam logic [3:0] TGT_DRAM = 4'd0;
  localparam logic [3:0] TGT_DEV  = 4'd1;
  localparam logic [3:0] TGT_PCI  = 4'd3;
  localparam logic [3:0] TGT_PCIE = 4'd4;
  localparam logic [7:0] ATTR_IO  = 8'h51;
  localparam logic [7:0] ATTR_MEM = 8'h59;
endpackage

// File: rtl/owin_regs.sv
module owin_regs
  import owin_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 4,
  parameter int CFG_AW    = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic [31:0]              cfg_wdata,
  output logic [31:0]              cfg_rdata,
  output owin_t [NUM_WIN-1:0]      win
);
  localparam int IW = CFG_AW - 4;

  logic [IW-1:0] idx;
  owin_reg_e     sel;
  logic          unused_lsb;

  assign idx        = cfg_addr[CFG_AW-1:4];
  assign sel        = owin_reg_e'(cfg_addr[3:2]);
  assign unused_lsb = ^cfg_addr[1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic                 wr_this;
    logic                 ctrl_en;
    logic                 base_en;
    logic [PAGE_BITS-1:0] span_q;
    logic [7:0]           attr_q;
    logic [3:0]           tgt_q;
    logic                 en_q;
    logic [PAGE_BITS-1:0] base_q;
    logic [PAGE_BITS-1:0] rlo_w;
    logic [31:0]          rhi_w;

    assign wr_this = cfg_wr && (idx == IW'(w));
    assign ctrl_en = wr_this && (sel == REG_CTRL);
    assign base_en = wr_this && (sel == REG_BASE);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        span_q <= '0;
        attr_q <= '0;
        tgt_q  <= '0;
        en_q   <= 1'b0;
        base_q <= '0;
      end else begin
        if (ctrl_en) begin
          span_q <= cfg_wdata[31:16];
          attr_q <= cfg_wdata[15:8];
          tgt_q  <= cfg_wdata[7:4];
          en_q   <= cfg_wdata[0];
        end
        if (base_en) begin
          base_q <= cfg_wdata[31:16];
        end
      end
    end

    if (w < NUM_REMAP) begin : g_remap
      logic                 rlo_en;
      logic                 rhi_en;
      logic [PAGE_BITS-1:0] rlo_q;
      logic [31:0]          rhi_q;
      assign rlo_en = wr_this && (sel == REG_RLO);
      assign rhi_en = wr_this && (sel == REG_RHI);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rlo_q <= '0;
          rhi_q <= '0;
        end else begin
          if (rlo_en) rlo_q <= cfg_wdata[31:16];
          if (rhi_en) rhi_q <= cfg_wdata;
        end
      end
      assign rlo_w = rlo_q;
      assign rhi_w = rhi_q;
    end else begin : g_plain
      assign rlo_w = '0;
      assign rhi_w = '0;
    end

    assign win[w] = '{span: span_q, attr: attr_q, tgt: tgt_q, en: en_q,
                      base: base_q, rlo: rlo_w, rhi: rhi_w};
  end

  always_comb begin
    cfg_rdata = '0;
    if (int'(idx) < NUM_WIN) begin
      unique case (sel)
        REG_CTRL: cfg_rdata = {win[idx].span, win[idx].attr, win[idx].tgt, 3'b000, win[idx].en};
        REG_BASE: cfg_rdata = {win[idx].base, 16'h0000};
        REG_RLO:  cfg_rdata = {win[idx].rlo, 16'h0000};
        REG_RHI:  cfg_rdata = win[idx].rhi;
        default:  cfg_rdata = '0;
      endcase
    end
  end

  // R4: base word low half always reads zero
  p_base_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == REG_BASE) |-> (cfg_rdata[15:0] == 16'h0000));

  // R5: windows without remap storage read zero at remap offsets
  p_no_remap_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(idx) >= NUM_REMAP) && cfg_addr[3]) |-> (cfg_rdata == 32'h0));

  // R3: reserved control bits stay zero
  p_ctrl_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == REG_CTRL) |-> (cfg_rdata[3:1] == 3'b000));
endmodule

// File: rtl/owin_match.sv
module owin_match
  import owin_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  owin_t [NUM_WIN-1:0] win,
  input  logic [31:0]         addr,
  output logic [NUM_WIN-1:0]  hit
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic [PAGE_BITS-1:0] diff;
    logic                 unused_fields;
    assign diff          = (addr[31:16] ^ win[w].base) & ~win[w].span;
    assign hit[w]        = win[w].en && (diff == '0);
    assign unused_fields = ^{win[w].attr, win[w].tgt, win[w].rlo, win[w].rhi};
  end
endmodule

// File: rtl/owin_pick.sv
module owin_pick
  import owin_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 4,
  parameter int IDX_W     = 3
) (
  input  owin_t [NUM_WIN-1:0] win,
  input  logic [NUM_WIN-1:0]  hit,
  input  logic [31:0]         addr,
  output logic [NUM_WIN-1:0]  grant,
  output logic                any,
  output logic [IDX_W-1:0]    idx,
  output logic [3:0]          tgt,
  output logic [7:0]          attr,
  output logic [31:0]         xaddr,
  output logic [31:0]         xhi
);
  logic unused_fields;
  always_comb begin
    unused_fields = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) begin
      unused_fields = unused_fields ^ (^{win[w].span, win[w].base, win[w].en});
    end
  end

  always_comb begin
    grant = '0;
    any   = 1'b0;
    idx   = '0;
    tgt   = '0;
    attr  = '0;
    xaddr = addr;
    xhi   = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (hit[w] && !any) begin
        any      = 1'b1;
        grant[w] = 1'b1;
        idx      = IDX_W'(w);
        tgt      = win[w].tgt;
        attr     = win[w].attr;
        if (w < NUM_REMAP) begin
          xaddr = {win[w].rlo, addr[15:0]};
          xhi   = win[w].rhi;
        end
      end
    end
  end
endmodule

// File: rtl/owin_unit.sv
module owin_unit
  import owin_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 4,
  localparam int IDX_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int CFG_AW   = IDX_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic [IDX_W-1:0]  res_win,
  output logic [3:0]        res_target,
  output logic [7:0]        res_attr,
  output logic [31:0]       res_addr,
  output logic [31:0]       res_addr_hi
);
  owin_t [NUM_WIN-1:0] win;
  logic [NUM_WIN-1:0]  hit;
  logic [NUM_WIN-1:0]  grant;
  logic                any;
  logic [IDX_W-1:0]    p_idx;
  logic [3:0]          p_tgt;
  logic [7:0]          p_attr;
  logic [31:0]         p_addr;
  logic [31:0]         p_hi;

  owin_regs #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .CFG_AW(CFG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .win(win)
  );

  owin_match #(.NUM_WIN(NUM_WIN)) u_match (
    .win(win), .addr(req_addr), .hit(hit)
  );

  owin_pick #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .IDX_W(IDX_W)) u_pick (
    .win(win), .hit(hit), .addr(req_addr), .grant(grant), .any(any),
    .idx(p_idx), .tgt(p_tgt), .attr(p_attr), .xaddr(p_addr), .xhi(p_hi)
  );

  // next-state
  logic              n_valid, n_hit, n_miss;
  logic [IDX_W-1:0]  n_win;
  logic [3:0]        n_tgt;
  logic [7:0]        n_attr;
  logic [31:0]       n_addr, n_hi;

  always_comb begin
    n_valid = req_valid;
    n_hit   = req_valid && any;
    n_miss  = req_valid && !any;
    n_win   = res_win;
    n_tgt   = res_target;
    n_attr  = res_attr;
    n_addr  = res_addr;
    n_hi    = res_addr_hi;
    if (req_valid) begin
      n_win  = p_idx;
      n_tgt  = p_tgt;
      n_attr = p_attr;
      n_addr = p_addr;
      n_hi   = p_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_hit     <= 1'b0;
      res_miss    <= 1'b0;
      res_win     <= '0;
      res_target  <= '0;
      res_attr    <= '0;
      res_addr    <= '0;
      res_addr_hi <= '0;
    end else begin
      res_valid   <= n_valid;
      res_hit     <= n_hit;
      res_miss    <= n_miss;
      res_win     <= n_win;
      res_target  <= n_tgt;
      res_attr    <= n_attr;
      res_addr    <= n_addr;
      res_addr_hi <= n_hi;
    end
  end

  // R10: one result cycle per request, none otherwise
  p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_hit && !res_miss));

  // R9: miss passes the requested address through
  p_miss_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_miss |-> (res_addr == $past(req_addr) && res_addr_hi == 32'h0 && !res_hit));

  // R7: at most one window wins, and one wins whenever any matches
  p_one_winner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((|grant) == (|hit)));

  // R8: windows without remap storage never translate
  p_plain_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_hit && (int'(res_win) >= NUM_REMAP)) |->
      (res_addr == $past(req_addr) && res_addr_hi == 32'h0));
endmodule

// File: tb/owin_unit_tb.sv
module owin_unit_tb;
  localparam int NW = 8;
  localparam int NR = 4;
  localparam int RW = 81;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        res_valid, res_hit, res_miss;
  logic [2:0]  res_win;
  logic [3:0]  res_target;
  logic [7:0]  res_attr;
  logic [31:0] res_addr, res_addr_hi;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] m_ctrl [NW];
  logic [31:0] m_base [NW];
  logic [31:0] m_rlo  [NW];
  logic [31:0] m_rhi  [NW];

  always #10 clk = ~clk;

  owin_unit #(.NUM_WIN(NW), .NUM_REMAP(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .res_valid(res_valid), .res_hit(res_hit),
    .res_miss(res_miss), .res_win(res_win), .res_target(res_target),
    .res_attr(res_attr), .res_addr(res_addr), .res_addr_hi(res_addr_hi)
  );

  task automatic chk(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input int w, input int r);
    case (r)
      0: return 32'hFFFF_FFF1;
      1: return 32'hFFFF_0000;
      2: return (w < NR) ? 32'hFFFF_0000 : 32'h0;
      default: return (w < NR) ? 32'hFFFF_FFFF : 32'h0;
    endcase
  endfunction

  task automatic model_wr(input int w, input int r, input logic [31:0] d);
    case (r)
      0: m_ctrl[w] = d & mask_of(w, 0);
      1: m_base[w] = d & mask_of(w, 1);
      2: m_rlo[w]  = d & mask_of(w, 2);
      default: m_rhi[w] = d & mask_of(w, 3);
    endcase
  endtask

  task automatic wr(input int w, input int r, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = {w[2:0], r[1:0], 2'b11}; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    model_wr(w, r, d);
  endtask

  task automatic rd(input int w, input int r, input string tag);
    @(negedge clk);
    cfg_addr = {w[2:0], r[1:0], 2'b00};
    #1;
    chk(tag, RW'(cfg_rdata), RW'(m_ctrl[w] & 0) | RW'(r == 0 ? m_ctrl[w] : r == 1 ? m_base[w] :
        r == 2 ? m_rlo[w] : m_rhi[w]));
  endtask

  function automatic logic [RW-1:0] expect_of(input logic [31:0] a);
    logic h; logic [2:0] wi; logic [3:0] tg; logic [7:0] at; logic [31:0] xa, xh;
    h = 0; wi = 0; tg = 0; at = 0; xa = a; xh = 0;
    for (int w = 0; w < NW; w++) begin
      if (!h && m_ctrl[w][0] &&
          (((a[31:16] ^ m_base[w][31:16]) & ~m_ctrl[w][31:16]) == 16'h0)) begin
        h = 1; wi = w[2:0]; tg = m_ctrl[w][7:4]; at = m_ctrl[w][15:8];
        if (w < NR) begin
          xa = {m_rlo[w][31:16], a[15:0]};
          xh = m_rhi[w];
        end
      end
    end
    return {h, !h, wi, tg, at, xa, xh};
  endfunction

  function automatic logic [RW-1:0] actual_res();
    return {res_hit, res_miss, res_win, res_target, res_attr, res_addr, res_addr_hi};
  endfunction

  task automatic lookup(input logic [31:0] a, input string tag);
    logic [RW-1:0] e;
    e = expect_of(a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R10 valid"}, RW'(res_valid), RW'(1));
    chk(tag, actual_res(), e);
  endtask

  task automatic set_win(input int w, input logic [15:0] span, input logic [7:0] at,
                         input logic [3:0] tg, input logic [31:0] base,
                         input logic [31:0] rlo, input logic [31:0] rhi);
    wr(w, 0, {span, at, tg, 4'b0001});
    wr(w, 1, base);
    wr(w, 2, rlo);
    wr(w, 3, rhi);
  endtask

  initial begin
    for (int w = 0; w < NW; w++) begin
      m_ctrl[w] = 0; m_base[w] = 0; m_rlo[w] = 0; m_rhi[w] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < 4; r++) rd(w, r, "R1 reset read");
    chk("R1 no result before request", RW'({res_valid, res_hit, res_miss}), RW'(0));
    lookup(32'h0000_0000, "R1 reset lookup");
    lookup(32'hFFFF_FFFF, "R1 reset lookup high");

    // R2 R3 R4 R5: addressing and field masks
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < 4; r++) wr(w, r, 32'hFFFF_FFFF);
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < 4; r++) rd(w, r, "R3 R4 R5 all-ones mask");
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < 4; r++)
        wr(w, r, 32'h8000_0000 | (w << 24) | (r << 20) | 32'h0003_FFFE);
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < 4; r++) rd(w, r, "R2 distinct word per offset");
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < 4; r++) wr(w, r, 32'h0);

    // R6 R7 R8: a map with overlaps in remap and plain slots
    set_win(0, 16'h0000, 8'h51, 4'd4, 32'hF000_0000, 32'h1234_0000, 32'h0000_0005);
    set_win(1, 16'h0001, 8'h51, 4'd3, 32'hF002_0000, 32'h0000_0000, 32'hCAFE_0001);
    set_win(2, 16'h0FFF, 8'h59, 4'd4, 32'hE000_0000, 32'hE000_0000, 32'h0000_0000);
    set_win(3, 16'h07FF, 8'h59, 4'd3, 32'hE800_0000, 32'h4000_0000, 32'h0000_0009);
    set_win(4, 16'h007F, 8'h0F, 4'd1, 32'hFF80_0000, 32'h0, 32'h0);
    set_win(5, 16'h000F, 8'h1E, 4'd1, 32'hFA00_0000, 32'h0, 32'h0);
    set_win(6, 16'h000F, 8'h1D, 4'd1, 32'hFB00_0000, 32'h0, 32'h0);
    set_win(7, 16'h00FF, 8'h1B, 4'd1, 32'hF000_0000, 32'h0, 32'h0);

    for (int w = 0; w < NW; w++) begin
      logic [31:0] b, s;
      b = m_base[w];
      s = ({16'h0, m_ctrl[w][31:16]} + 1) << 16;
      lookup(b, "R6 base edge");
      lookup(b + s - 1, "R6 top edge");
      lookup(b + s, "R6 past top");
      lookup(b - 1, "R6 below base");
      lookup(b + (s >> 1) + 32'h0000_1357, "R8 mid window");
    end
    lookup(32'hE900_4321, "R7 overlap remap slots");
    lookup(32'hF000_ABCD, "R7 overlap remap over plain");
    lookup(32'hF0F0_0000, "R7 plain slot behind");
    lookup(32'h1000_0042, "R9 miss");

    for (int k = 0; k < 65536; k += 7)
      lookup({k[15:0], 16'(k * 40503)}, "R6 R7 R8 R9 sweep");

    // R5: writes to missing remap words change nothing visible
    wr(5, 2, 32'hABCD_0000);
    wr(5, 3, 32'h1111_2222);
    rd(5, 2, "R5 ignored remap low");
    rd(5, 3, "R5 ignored remap high");
    lookup(32'hFA05_0010, "R5 R8 plain window untouched");

    // R7: remove winner, lower priority takes over
    wr(2, 0, 32'h0);
    lookup(32'hE900_4321, "R7 after winner disabled");
    lookup(32'hE100_0000, "R7 uncovered after disable");

    // R11: same-cycle write and lookup uses old contents
    begin
      logic [RW-1:0] e_old;
      e_old = expect_of(32'hFB00_1234);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = {3'd6, 2'd0, 2'b00}; cfg_wdata = 32'h0;
      req_valid = 1'b1; req_addr = 32'hFB00_1234;
      @(negedge clk);
      cfg_wr = 1'b0; req_valid = 1'b0;
      model_wr(6, 0, 32'h0);
      chk("R11 same-cycle uses old map", actual_res(), e_old);
      lookup(32'hFB00_1234, "R11 next lookup sees new map");
    end

    // R10: back-to-back then idle
    begin
      logic [RW-1:0] ea, eb;
      ea = expect_of(32'hF000_0001);
      eb = expect_of(32'hFF81_0000);
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'hF000_0001;
      @(negedge clk);
      req_addr = 32'hFF81_0000;
      chk("R10 first of pair", actual_res(), ea);
      chk("R10 first valid", RW'(res_valid), RW'(1));
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 second of pair", actual_res(), eb);
      chk("R10 second valid", RW'(res_valid), RW'(1));
      @(negedge clk);
      chk("R10 idle flags", RW'({res_valid, res_hit, res_miss}), RW'(0));
      chk("R10 idle holds data", RW'({res_win, res_target, res_attr, res_addr, res_addr_hi}),
          RW'(eb[78:0]));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule